// File: doc/BRIEF.md
# Keyboard Matrix and Beeper Port

This block is the single peripheral I/O port of a home-computer support chip. It sits on an 8-bit CPU bus with a 16-bit I/O address and active-low IORQ, RD and WR strobes. The port answers every I/O access that has address bit 0 low. No other address bit takes part in that decision.

A read drives the upper address byte onto eight active-low half-row select lines of the key matrix. Any number of half-rows may be selected at once. The matrix joins the key columns of all selected half-rows with a wired-AND and returns five active-low column lines. The block places these lines in read bits 4:0 and the tape input in bit 6. A write loads a small register that holds a 3-bit border colour, the tape-output bit and the speaker bit.

The half-rows sit on address bits 8 to 15 in this order: Caps Shift–V, A–G, Q–T, 1–5, 0–6, P–Y, Enter–H, Space–B. Columns count outward from the edge key of each half-row. Key debouncing, the analogue tape path and video generation are handled elsewhere.

Top module: `kbd_port_io`

## Requirements
- R1: A port access is recognised only when iorq_ni is 0 and addr_i[0] is 0. Address bits 15:1 never affect whether the port is selected.
- R2: During a port read (iorq_ni, rd_ni and addr_i[0] all 0), row_sel_no[k] equals addr_i[8+k], so a 0 selects half-row k. At every other time row_sel_no is all ones.
- R3: During a port read, data_o[4:0] equals col_ni[4:0]. A column reads 0 when its key is held on any selected half-row.
- R4: During a port read, data_o[6] equals ear_i, and data_o[5] and data_o[7] read 0.
- R5: data_oe_o is 1 exactly during a port read. While data_oe_o is 0, data_o reads 8'hFF.
- R6: On a rising clock edge during a port write (iorq_ni, wr_ni and addr_i[0] all 0), border_o takes data_i[2:0], mic_o takes data_i[3] and spk_o takes data_i[4]. addr_i[15:8] and data_i[7:5] have no effect on the result.
- R7: While rst_ni is 0, border_o, mic_o and spk_o are 0.
- R8: The outputs border_o, mic_o and spk_o keep their value on every clock edge that is not a port write. This includes writes with addr_i[0] = 1, and port reads.
- R9: Suppose Caps Shift (half-row 0, column 0), T (half-row 2, column 4) and O (half-row 5, column 1) are held, and a read is made at address 0xDEFE with ear_i at 0. Then data_o is 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iorq_ni | input | 1 | I/O request strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 16 | I/O address |
| data_i | input | 8 | Write data from the CPU |
| data_o | output | 8 | Read data to the CPU |
| data_oe_o | output | 1 | Read data enable for the bus driver |
| row_sel_no | output | 8 | Half-row select lines, active low |
| col_ni | input | 5 | Wired-AND key column lines, active low |
| ear_i | input | 1 | Tape input |
| border_o | output | 3 | Border colour |
| mic_o | output | 1 | Tape output |
| spk_o | output | 1 | Speaker output |

## Verification
A port read and a port write are decoded separately, so both can occur in the same cycle. In that cycle the output register loads while the read path drives the key columns. The bench provokes this by random stimulus that holds IORQ, RD and WR low together. It then judges two things against its reference model. The read byte must carry only the key and tape state and must not show the byte being written. The border, MIC and speaker outputs must show the written byte after that edge. A key-matrix model in the bench forms the column lines from the block's own row outputs, so a wrong row drive appears as wrong read data.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ROW_N    = 8;
  localparam int unsigned COL_N    = 5;
  localparam int unsigned BORDER_W = 3;
  localparam int unsigned EAR_BIT  = 6;

  typedef struct packed {
    logic                spk;
    logic                mic;
    logic [BORDER_W-1:0] border;
  } out_reg_t;
endpackage

// File: rtl/kbd_port_decode.sv
module kbd_port_decode (
  input  logic iorq_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  input  logic sel_bit_i,
  output logic rd_hit_o,
  output logic wr_hit_o
);
  logic port_hit;
  // partial decode: a single low address bit selects the port
  assign port_hit = ~iorq_ni & ~sel_bit_i;
  assign rd_hit_o = port_hit & ~rd_ni;
  assign wr_hit_o = port_hit & ~wr_ni;
endmodule

// File: rtl/kbd_port_rdmux.sv
module kbd_port_rdmux #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ROW_N   = 8,
  parameter int unsigned COL_N   = 5,
  parameter int unsigned EAR_BIT = 6
) (
  input  logic              rd_hit_i,
  input  logic [ROW_N-1:0]  addr_hi_i,
  input  logic [COL_N-1:0]  col_ni,
  input  logic              ear_i,
  output logic [ROW_N-1:0]  row_sel_no,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  for (genvar r = 0; r < ROW_N; r++) begin : g_row
    assign row_sel_no[r] = rd_hit_i ? addr_hi_i[r] : 1'b1;
  end

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word              = '0;
    rd_word[COL_N-1:0]   = col_ni;
    rd_word[EAR_BIT]     = ear_i;
  end

  assign data_o    = rd_hit_i ? rd_word : '1;
  assign data_oe_o = rd_hit_i;
endmodule

// File: rtl/kbd_port_outreg.sv
module kbd_port_outreg #(
  parameter int unsigned BORDER_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [BORDER_W+1:0] wdata_i,
  output logic [BORDER_W-1:0] border_o,
  output logic                mic_o,
  output logic                spk_o
);
  import kbd_port_pkg::*;
  out_reg_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (load_i) begin
      q.border <= wdata_i[BORDER_W-1:0];
      q.mic    <= wdata_i[BORDER_W];
      q.spk    <= wdata_i[BORDER_W+1];
    end
  end

  assign border_o = q.border;
  assign mic_o    = q.mic;
  assign spk_o    = q.spk;
endmodule

// File: rtl/kbd_port_io.sv
module kbd_port_io
  import kbd_port_pkg::*;
#(
  parameter int unsigned P_ADDR_W   = ADDR_W,
  parameter int unsigned P_DATA_W   = DATA_W,
  parameter int unsigned P_ROW_N    = ROW_N,
  parameter int unsigned P_COL_N    = COL_N,
  parameter int unsigned P_BORDER_W = BORDER_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  iorq_ni,
  input  logic                  rd_ni,
  input  logic                  wr_ni,
  input  logic [P_ADDR_W-1:0]   addr_i,
  input  logic [P_DATA_W-1:0]   data_i,
  output logic [P_DATA_W-1:0]   data_o,
  output logic                  data_oe_o,
  output logic [P_ROW_N-1:0]    row_sel_no,
  input  logic [P_COL_N-1:0]    col_ni,
  input  logic                  ear_i,
  output logic [P_BORDER_W-1:0] border_o,
  output logic                  mic_o,
  output logic                  spk_o
);
  localparam int unsigned ROW_LSB = P_ADDR_W - P_ROW_N;
  localparam int unsigned WR_W    = P_BORDER_W + 2;

  logic rd_hit, wr_hit;

  kbd_port_decode u_dec (
    .iorq_ni  (iorq_ni),
    .rd_ni    (rd_ni),
    .wr_ni    (wr_ni),
    .sel_bit_i(addr_i[0]),
    .rd_hit_o (rd_hit),
    .wr_hit_o (wr_hit)
  );

  kbd_port_rdmux #(
    .DATA_W (P_DATA_W),
    .ROW_N  (P_ROW_N),
    .COL_N  (P_COL_N),
    .EAR_BIT(EAR_BIT)
  ) u_rd (
    .rd_hit_i  (rd_hit),
    .addr_hi_i (addr_i[P_ADDR_W-1:ROW_LSB]),
    .col_ni    (col_ni),
    .ear_i     (ear_i),
    .row_sel_no(row_sel_no),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
  );

  kbd_port_outreg #(
    .BORDER_W(P_BORDER_W)
  ) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wr_hit),
    .wdata_i (data_i[WR_W-1:0]),
    .border_o(border_o),
    .mic_o   (mic_o),
    .spk_o   (spk_o)
  );

  logic unused_bits;
  assign unused_bits = ^{addr_i[ROW_LSB-1:1], data_i[P_DATA_W-1:WR_W]};
endmodule

// File: rtl/kbd_port_io_chk.sv
module kbd_port_io_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        iorq_ni,
  input logic        rd_ni,
  input logic        wr_ni,
  input logic [15:0] addr_i,
  input logic [7:0]  data_i,
  input logic [7:0]  data_o,
  input logic        data_oe_o,
  input logic [7:0]  row_sel_no,
  input logic [2:0]  border_o,
  input logic        mic_o,
  input logic        spk_o
);
  p_enable_needs_a0_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!addr_i[0] && !iorq_ni && !rd_ni));

  p_rows_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (row_sel_no == 8'hFF));

  p_rows_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (row_sel_no == addr_i[15:8]));

  p_unused_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!data_o[7] && !data_o[5]));

  p_idle_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == 8'hFF));

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!iorq_ni && !wr_ni && !addr_i[0]) |=> ({spk_o, mic_o, border_o} == $past(data_i[4:0])));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iorq_ni || wr_ni || addr_i[0]) |=> $stable({spk_o, mic_o, border_o}));
endmodule

bind kbd_port_io kbd_port_io_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .iorq_ni   (iorq_ni),
  .rd_ni     (rd_ni),
  .wr_ni     (wr_ni),
  .addr_i    (addr_i),
  .data_i    (data_i),
  .data_o    (data_o),
  .data_oe_o (data_oe_o),
  .row_sel_no(row_sel_no),
  .border_o  (border_o),
  .mic_o     (mic_o),
  .spk_o     (spk_o)
);

// File: tb/tb_kbd_port_io.sv
module tb_kbd_port_io;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] addr = 16'hFFFF;
  logic [7:0]  wdata = 8'h00;
  logic        ear = 1'b0;
  logic [7:0]  data_o, row_sel_n;
  logic        data_oe;
  logic [4:0]  col_n;
  logic [2:0]  border;
  logic        mic, spk;

  logic [4:0]  keys [8];
  logic [4:0]  m_reg;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_port_io dut (
    .clk_i(clk), .rst_ni(rst_n), .iorq_ni(iorq_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(wdata), .data_o(data_o), .data_oe_o(data_oe),
    .row_sel_no(row_sel_n), .col_ni(col_n), .ear_i(ear),
    .border_o(border), .mic_o(mic), .spk_o(spk)
  );

  // key matrix: wired-AND of every half-row the block pulls low
  always_comb begin
    col_n = 5'h1F;
    for (int r = 0; r < 8; r++)
      if (!row_sel_n[r]) col_n = col_n & ~keys[r];
  end

  // reference register model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reg <= 5'h00;
    else if (!iorq_n && !wr_n && !addr[0]) m_reg <= wdata[4:0];
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic       hit;
    logic [4:0] cols;
    hit = !iorq_n && !rd_n && !addr[0];
    cols = 5'h1F;
    for (int r = 0; r < 8; r++)
      if (!addr[8+r]) cols = cols & ~keys[r];
    check("R5 data_oe", {15'd0, data_oe}, {15'd0, hit});
    check("R2 row_sel", {8'd0, row_sel_n}, {8'd0, hit ? addr[15:8] : 8'hFF});
    check("R3/R4/R5 data", {8'd0, data_o}, {8'd0, hit ? {1'b0, ear, 1'b0, cols} : 8'hFF});
    check("R6/R8 regs", {11'd0, spk, mic, border}, {11'd0, m_reg});
  endtask

  task automatic cyc(input logic io, input logic r, input logic w,
                     input logic [15:0] a, input logic [7:0] d, input logic e);
    @(posedge clk); #1;
    iorq_n = io; rd_n = r; wr_n = w; addr = a; wdata = d; ear = e;
    @(negedge clk);
    compare_all();
  endtask

  task automatic clear_keys();
    for (int r = 0; r < 8; r++) keys[r] = 5'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clear_keys();
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 reset regs", {11'd0, spk, mic, border}, 16'd0);
    wdata = 8'hFF; iorq_n = 1'b0; wr_n = 1'b0; addr = 16'h00FE;
    @(negedge clk);
    check("R7 reset holds under write", {11'd0, spk, mic, border}, 16'd0);
    iorq_n = 1'b1; wr_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;

    // R9: worked example
    keys[0] = 5'b00001; keys[2] = 5'b10000; keys[5] = 5'b00010;
    cyc(0, 0, 1, 16'hDEFE, 8'h00, 0);
    check("R9 example", {8'd0, data_o}, 16'h001C);
    cyc(0, 0, 1, 16'hFBFE, 8'h00, 1);
    check("R3 single row Q-T", {8'd0, data_o}, 16'h004F);

    // R1: odd address is not the port, upper bits irrelevant
    cyc(0, 0, 1, 16'hDEFF, 8'h00, 0);
    check("R1 odd read", {7'd0, data_oe, data_o}, 16'h00FF);
    cyc(0, 1, 0, 16'h1235, 8'h1F, 0);
    cyc(1, 1, 1, 16'hFFFF, 8'h00, 0);
    check("R1/R8 odd write ignored", {11'd0, spk, mic, border}, 16'd0);
    cyc(0, 1, 0, 16'hA55A, 8'hEA, 0);
    cyc(1, 1, 1, 16'hFFFF, 8'h00, 0);
    check("R6 write loads low bits", {11'd0, spk, mic, border}, 16'h000A);
    cyc(0, 1, 0, 16'h0000, 8'hF5, 0);
    cyc(0, 0, 1, 16'h00FE, 8'h00, 0);
    check("R8 read holds reg", {11'd0, spk, mic, border}, 16'h0015);
    cyc(1, 0, 0, 16'h0000, 8'h00, 0);
    check("R1 no iorq no effect", {11'd0, spk, mic, border, data_oe}, 16'h002A);

    // random traffic incl. simultaneous read and write
    for (int i = 0; i < 2000; i++) begin
      if (i % 50 == 0)
        for (int r = 0; r < 8; r++) keys[r] = 5'($urandom) & 5'($urandom);
      cyc(1'($urandom % 3 == 0), 1'($urandom), 1'($urandom),
          16'($urandom), 8'($urandom), 1'($urandom));
    end
    // R7: asynchronous reset clears register mid-run
    cyc(0, 1, 0, 16'h0000, 8'h1F, 0);
    #1 rst_n = 1'b0; #1;
    check("R7 async clear", {11'd0, spk, mic, border}, 16'd0);
    finish_run();
  end
endmodule